// File: doc/BRIEF.md
# Transmit Frame and Multiframe Sync Pulse Generator

This block follows the bit position inside a transmit frame and the frame position inside a multiframe, for either T1 framing (193 bits per frame) or E1 framing (256 bits per frame). Every action happens on the rising edge of the transmit line clock. At the system level that clock runs at 1.544 MHz for T1 and at 2.048 MHz for E1, so a frame boundary comes around at 8 kHz.

The sync line can work in one of two directions, chosen by `sync_is_out`. As an input, a rising edge on `sync_in` moves the counters to a frame boundary. When multiframe alignment is selected, the same edge also moves them to a multiframe boundary. As an output, the block drives `sync_out` high for one clock at each frame boundary, or at each multiframe boundary only. With T1 frame pulses, the pulse can be stretched to two clocks in the signaling frames. Frame and multiframe lengths are parameters. The T1 multiframe is 12 frames or 24 frames, chosen by `esf_sel`. The E1 multiframe is 16 frames.

Top module: `tx_sync_gen`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) sets the bit index and the frame index to zero. With output direction and frame pulses selected, `sync_out` is therefore 1 in the first cycle after reset is released.
- R2: In output direction with frame pulses selected, frame pulses are exactly 193 clocks apart when `e1_mode`=0 and exactly 256 clocks apart when `e1_mode`=1.
- R3: In output direction with frame pulses selected (`mf_sel`=0), `sync_out` is 1 for a single clock, at bit index 0 of every frame. The double-wide cases of R5 are the only exception.
- R4: In output direction with `mf_sel`=1, `sync_out` is 1 only at bit index 0 of frame index 0. The multiframe length is 12 frames (T1, `esf_sel`=0), 24 frames (T1, `esf_sel`=1) or 16 frames (E1).
- R5: When `dbl_wide_en`=1, `e1_mode`=0 and `mf_sel`=0, `sync_out` also stays 1 at bit index 1 of the signaling frames. These are the frames whose 0-based index gives 5 when divided by 6 (frames 5 and 11, plus 17 and 23 in the 24-frame multiframe). `dbl_wide_en` has no effect in E1 mode or when multiframe pulses are selected.
- R6: In input direction (`sync_is_out`=0), `sync_out` is held at 0.
- R7: In input direction, a clock edge at which `sync_in` is 1 after being 0 at the previous edge sets the bit index to 0. With `mf_sel`=0 it also advances the frame index by one.
- R8: In input direction with `mf_sel`=1, such a rising edge also sets the frame index to 0.
- R9: In output direction, `sync_in` has no effect on the counters.
- R10: An input sync edge that falls on the last bit of a frame gives the same counter state as the natural wrap. The frame index advances once, not twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit line clock |
| rst_n | input | 1 | Synchronous reset, active low |
| e1_mode | input | 1 | 1 selects E1 framing, 0 selects T1 framing |
| esf_sel | input | 1 | T1 only: 1 selects the 24-frame multiframe, 0 the 12-frame one |
| sync_is_out | input | 1 | 1 drives pulses on `sync_out`; 0 takes alignment from `sync_in` |
| mf_sel | input | 1 | 1 works on multiframe boundaries, 0 on frame boundaries |
| dbl_wide_en | input | 1 | Stretches T1 frame pulses in signaling frames to two clocks |
| sync_in | input | 1 | Alignment pulse, used in input direction |
| sync_out | output | 1 | Generated frame or multiframe pulse |

## Verification
Two functions can fall in the same cycle. One is the realignment from an input sync edge. The other is the counter's natural wrap at the last bit of a frame. The bench provokes this by raising `sync_in` exactly when its reference model puts the design on the last bit. It then switches the line to output direction and requires the later frame pulses, and in multiframe mode the multiframe pulse, to keep the undisturbed schedule, which shows the frame index moved by one step only. The bench also lands an edge in the middle of a frame, both with and without multiframe alignment, to separate a realignment from a wrap.

// File: rtl/tsg_pkg.sv
// Package: shared constants for the transmit sync pulse generator.
// Assumes: frame bit counts and multiframe frame counts are fixed by the
// framing standard; the numbers below are the defaults used by the top.
package tsg_pkg;

    localparam int T1_BITS_DEF   = 193;
    localparam int E1_BITS_DEF   = 256;
    localparam int T1_SF_DEF     = 12;
    localparam int T1_ESF_DEF    = 24;
    localparam int E1_MF_DEF     = 16;
    localparam int SIG_EVERY_DEF = 6;

    // Return the larger of two sizes (used to size shared counters).
    function automatic int tsg_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tsg_sync_in.sv
// Module: tsg_sync_in
// Detects a rising edge on the external sync line and turns it into a
// one-clock realign strobe, only while the line is used as an input.
// Assumes: sync_in is already synchronous to clk.
module tsg_sync_in (
    input  logic clk,
    input  logic rst_n,
    input  logic listen,
    input  logic sync_in,
    output logic realign
);

    logic sin_q;

    // Remember the previous sample of the sync line.
    always_ff @(posedge clk) begin
        if (!rst_n) sin_q <= 1'b0;
        else        sin_q <= sync_in;
    end

    // Strobe on a 0-to-1 transition while listening.
    always_comb realign = listen & sync_in & ~sin_q;

    // A strobe can never repeat on the next clock (edge, not level).
    p_edge_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> !realign);

endmodule

// File: rtl/tsg_bit_ctr.sv
// Module: tsg_bit_ctr
// Bit index inside the current frame. Wraps after last_bit, or returns
// to zero on a realign strobe; flags the natural wrap to the frame counter.
// Assumes: last_bit may change only while the design is idle or in reset.
module tsg_bit_ctr #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] last_bit,
    input  logic          realign,
    output logic [BW-1:0] bit_idx,
    output logic          wrap
);

    // Natural end of frame; a realign in the same cycle takes precedence.
    always_comb wrap = !realign && (bit_idx >= last_bit);

    // Advance, wrap or realign the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n)                bit_idx <= '0;
        else if (realign || wrap)  bit_idx <= '0;
        else                       bit_idx <= bit_idx + 1'b1;
    end

    // Inside a frame the index moves by exactly one per clock.
    p_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!realign && bit_idx < last_bit) |=> bit_idx == $past(bit_idx) + 1'b1);

    // A realign strobe lands the index on zero at the next clock.
    p_realign_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        realign |=> bit_idx == '0);

endmodule

// File: rtl/tsg_frame_ctr.sv
// Module: tsg_frame_ctr
// Frame index inside the multiframe. Steps once per frame start and is
// cleared by a multiframe realign.
// Assumes: advance and clear are one-clock strobes from the bit counter
// and the sync input stage.
module tsg_frame_ctr #(
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] last_frm,
    input  logic          advance,
    input  logic          clear,
    output logic [FW-1:0] frm_idx
);

    // Clear, step with wrap, or hold the frame index.
    always_ff @(posedge clk) begin
        if (!rst_n)                frm_idx <= '0;
        else if (clear)            frm_idx <= '0;
        else if (advance) begin
            if (frm_idx >= last_frm) frm_idx <= '0;
            else                     frm_idx <= frm_idx + 1'b1;
        end
    end

    // A multiframe realign puts the frame index on zero.
    p_mf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> frm_idx == '0);

    // Without a strobe the frame index holds.
    p_frm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(frm_idx));

endmodule

// File: rtl/tsg_pulse_shaper.sv
// Module: tsg_pulse_shaper
// Decodes the counter state into the outgoing sync pulse: frame or
// multiframe boundary, stretched to two clocks in T1 signaling frames.
// Assumes: counters are registered, so the output is glitch-free decode.
module tsg_pulse_shaper #(
    parameter int BW        = 8,
    parameter int FW        = 5,
    parameter int SIG_EVERY = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drive,
    input  logic          e1_mode,
    input  logic          mf_sel,
    input  logic          dbl_wide_en,
    input  logic [BW-1:0] bit_idx,
    input  logic [FW-1:0] frm_idx,
    output logic          pulse
);

    localparam logic [FW-1:0] SIG_LAST = FW'(SIG_EVERY - 1);
    localparam logic [FW-1:0] SIG_MOD  = FW'(SIG_EVERY);

    logic at_boundary;
    logic sig_frame;
    logic stretch;

    // Boundary decode: every frame, or frame zero only in multiframe mode.
    always_comb at_boundary = (bit_idx == '0) && (!mf_sel || frm_idx == '0);

    // Signaling frame: the last frame of each group of SIG_EVERY frames.
    always_comb sig_frame = ((frm_idx % SIG_MOD) == SIG_LAST);

    // Second clock of a stretched pulse, T1 frame pulses only.
    always_comb stretch = dbl_wide_en && !e1_mode && !mf_sel &&
                          sig_frame && (bit_idx == BW'(1));

    // Drive the pulse only when the line is an output.
    always_comb pulse = drive && (at_boundary || stretch);

    // A pulse seen at bit 1 can only be the T1 stretch.
    p_wide_t1_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && bit_idx == BW'(1)) |-> (!e1_mode && dbl_wide_en && !mf_sel));

endmodule

// File: rtl/tx_sync_gen.sv
// Module: tx_sync_gen (top)
// Transmit frame/multiframe sync generator. Tracks bit and frame position
// for T1 or E1 framing; either aligns to an incoming sync edge or emits
// frame / multiframe pulses on sync_out.
// Assumes: every input is synchronous to clk; framing mode changes are
// made with reset asserted.
module tx_sync_gen #(
    parameter int T1_FRAME_BITS = tsg_pkg::T1_BITS_DEF,
    parameter int E1_FRAME_BITS = tsg_pkg::E1_BITS_DEF,
    parameter int T1_SF_FRAMES  = tsg_pkg::T1_SF_DEF,
    parameter int T1_ESF_FRAMES = tsg_pkg::T1_ESF_DEF,
    parameter int E1_MF_FRAMES  = tsg_pkg::E1_MF_DEF,
    parameter int SIG_EVERY     = tsg_pkg::SIG_EVERY_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e1_mode,
    input  logic esf_sel,
    input  logic sync_is_out,
    input  logic mf_sel,
    input  logic dbl_wide_en,
    input  logic sync_in,
    output logic sync_out
);

    localparam int MAX_BITS = tsg_pkg::tsg_max(T1_FRAME_BITS, E1_FRAME_BITS);
    localparam int MAX_FRMS = tsg_pkg::tsg_max(tsg_pkg::tsg_max(T1_SF_FRAMES, T1_ESF_FRAMES),
                                               E1_MF_FRAMES);
    localparam int BW = $clog2(MAX_BITS);
    localparam int FW = $clog2(MAX_FRMS);

    localparam logic [BW-1:0] T1_LAST  = BW'(T1_FRAME_BITS - 1);
    localparam logic [BW-1:0] E1_LAST  = BW'(E1_FRAME_BITS - 1);
    localparam logic [FW-1:0] SF_LAST  = FW'(T1_SF_FRAMES - 1);
    localparam logic [FW-1:0] ESF_LAST = FW'(T1_ESF_FRAMES - 1);
    localparam logic [FW-1:0] E1M_LAST = FW'(E1_MF_FRAMES - 1);

    logic [BW-1:0] last_bit;
    logic [FW-1:0] last_frm;
    logic [BW-1:0] bit_idx;
    logic [FW-1:0] frm_idx;
    logic          realign;
    logic          wrap;
    logic          frm_step;
    logic          frm_clear;

    // Frame length selection by framing mode.
    always_comb last_bit = e1_mode ? E1_LAST : T1_LAST;

    // Multiframe length selection by framing mode and T1 multiframe type.
    always_comb last_frm = e1_mode ? E1M_LAST : (esf_sel ? ESF_LAST : SF_LAST);

    // Frame counter strobes: one step per frame start, clear on mf realign.
    always_comb begin
        frm_clear = realign && mf_sel;
        frm_step  = wrap || (realign && !mf_sel);
    end

    tsg_sync_in u_sync_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .listen  (!sync_is_out),
        .sync_in (sync_in),
        .realign (realign)
    );

    tsg_bit_ctr #(.BW(BW)) u_bit_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_bit (last_bit),
        .realign  (realign),
        .bit_idx  (bit_idx),
        .wrap     (wrap)
    );

    tsg_frame_ctr #(.FW(FW)) u_frame_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_frm (last_frm),
        .advance  (frm_step),
        .clear    (frm_clear),
        .frm_idx  (frm_idx)
    );

    tsg_pulse_shaper #(.BW(BW), .FW(FW), .SIG_EVERY(SIG_EVERY)) u_shaper (
        .clk         (clk),
        .rst_n       (rst_n),
        .drive       (sync_is_out),
        .e1_mode     (e1_mode),
        .mf_sel      (mf_sel),
        .dbl_wide_en (dbl_wide_en),
        .bit_idx     (bit_idx),
        .frm_idx     (frm_idx),
        .pulse       (sync_out)
    );

    // The sync output stays quiet whenever the line is an input.
    p_in_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_is_out |-> !sync_out);

    // Without stretching, an output pulse lasts one clock.
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_is_out && !dbl_wide_en && sync_out) |=> (!sync_out || dbl_wide_en));

    // In output direction the sync input never realigns the counters.
    p_out_ignores_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_is_out |-> !realign);

    // Realign and natural wrap never step the frame index twice.
    p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(realign && wrap));

endmodule

// File: tb/test_tx_sync_gen.sv
// Scoreboard bench for tx_sync_gen. The driver applies inputs at the
// falling edge, advances a reference model of bit/frame position and
// pushes the expected sync_out; a monitor pops and compares shortly
// after each rising edge.
module test_tx_sync_gen;

    typedef struct {
        bit    exp;
        string tag;
    } item_t;

    logic clk = 1'b0;
    logic d_rst_n = 1'b0, d_e1 = 1'b0, d_esf = 1'b0, d_out = 1'b1;
    logic d_mf = 1'b0, d_dbl = 1'b0, d_sin = 1'b0;
    logic d_sout;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    item_t q[$];

    int bitm = 0, frmm = 0;
    bit prevm = 1'b0;

    always #4 clk = ~clk;

    tx_sync_gen i_tx_sync_gen (
        .clk         (clk),
        .rst_n       (d_rst_n),
        .e1_mode     (d_e1),
        .esf_sel     (d_esf),
        .sync_is_out (d_out),
        .mf_sel      (d_mf),
        .dbl_wide_en (d_dbl),
        .sync_in     (d_sin),
        .sync_out    (d_sout)
    );

    function automatic int flen();
        return d_e1 ? 256 : 193;
    endfunction

    function automatic int mlen();
        return d_e1 ? 16 : (d_esf ? 24 : 12);
    endfunction

    function automatic bit wide_bit();
        return d_dbl && !d_e1 && !d_mf && bitm == 1 && (frmm % 6) == 5;
    endfunction

    function automatic bit expect_out();
        if (!d_out) return 1'b0;
        return (bitm == 0 && (!d_mf || frmm == 0)) || wide_bit();
    endfunction

    function automatic string auto_tag();
        if (!d_out)                      return "R6";
        if (d_dbl && bitm == 1)          return "R5";
        if (d_mf)                        return "R4";
        if (bitm == 0)                   return "R2";
        return "R3";
    endfunction

    // One clock: update the model for the coming edge, queue the expectation.
    task automatic step(input string tag);
        item_t it;
        bit rl;
        if (!d_rst_n) begin
            bitm = 0; frmm = 0; prevm = 1'b0;
        end else begin
            rl = !d_out && d_sin && !prevm;
            if (rl) begin
                bitm = 0;
                frmm = d_mf ? 0 : (frmm + 1) % mlen();
            end else if (bitm >= flen() - 1) begin
                bitm = 0;
                frmm = (frmm + 1) % mlen();
            end else begin
                bitm = bitm + 1;
            end
            prevm = d_sin;
        end
        it.exp = expect_out();
        it.tag = (tag == "") ? auto_tag() : tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Reset with a given configuration, then check the first cycle (R1).
    task automatic restart(input bit e1, input bit esf, input bit mf,
                           input bit dbl, input bit outdir);
        d_rst_n = 1'b0; d_e1 = e1; d_esf = esf; d_mf = mf;
        d_dbl = dbl; d_out = outdir; d_sin = 1'b0;
        run(2, "R1");
        d_rst_n = 1'b1;
        step("R1");
    endtask

    // Single-clock sync pulse on the input line.
    task automatic pulse_in(input string tag);
        d_sin = 1'b1; step(tag);
        d_sin = 1'b0; step(tag);
    endtask

    // Monitor: compare the output with the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                total++;
                if (d_sout !== it.exp) begin
                    bad++;
                    $display("FAIL %s sync_out actual=%b expected=%b at %0t",
                             it.tag, d_sout, it.exp, $time);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1, R2, R3: T1 frame pulses, then E1 frame pulses.
        restart(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run(193 * 3, "");
        restart(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        run(256 * 3, "");
        // R4: multiframe pulses for the three multiframe lengths.
        restart(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
        run(193 * 12 * 2 + 5, "R4");
        restart(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        run(193 * 24 * 2 + 5, "R4");
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        run(256 * 16 * 2 + 5, "R4");
        // R5: double-wide in T1 12- and 24-frame; ignored in E1 and mf.
        restart(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        run(193 * 13, "R5");
        restart(1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
        run(193 * 25, "R5");
        restart(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        run(256 * 7, "R5");
        restart(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        run(193 * 13, "R5");
        // R6, R7: input direction, mid-frame realign, then observe.
        restart(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run(50, "R6");
        pulse_in("R7");
        run(30, "R6");
        d_out = 1'b1;
        run(193 * 7, "R7");
        // R8: multiframe realign in the middle of a multiframe.
        restart(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run(193 * 3 + 77, "R6");
        pulse_in("R8");
        d_out = 1'b1;
        run(193 * 25, "R8");
        // R8 in E1 framing.
        restart(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        run(256 * 5 + 10, "R6");
        pulse_in("R8");
        d_out = 1'b1;
        run(256 * 17, "R8");
        // R9: sync_in toggling in output direction has no effect.
        restart(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        run(40, "R9");
        for (int k = 0; k < 6; k++) begin
            pulse_in("R9");
            run(17, "R9");
        end
        run(193 * 2, "R9");
        // R10: edge on the last bit of a frame, frame pulses with stretch.
        restart(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        run(193 * 4 + 191, "R6");
        pulse_in("R10");
        d_out = 1'b1;
        run(193 * 13, "R10");
        // R10 in multiframe mode on the last bit of the last frame.
        restart(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        run(193 * 12 - 2, "R6");
        pulse_in("R10");
        d_out = 1'b1;
        run(193 * 13, "R10");

        @(posedge clk);
        #2;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule